// File: doc/BRIEF.md
# SD Card Command Path Engine

This block runs one host command exchange on the single-wire card command line. Software loads a 32-bit argument, then writes a command word that carries a 6-bit command index, a 2-bit response type and a go bit. The engine then shifts out a 48-bit command frame, most significant bit first, that ends in a CRC7. Depending on the response type it then stops, or it waits for the card to answer with a 48-bit or a 136-bit frame. Received content goes into four 32-bit response words. The outcome is recorded in sticky status flags that can be masked onto one interrupt line and are cleared by writing ones.

All card-side activity advances only on cycles where `card_tick` is high, so a clock divider outside the block sets the card bit rate. The line is driven only while the command frame is being sent; otherwise the output enable is low and the card (or a pull-up) owns the line.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset the engine is idle: status reads zero, `cmd_oe` is low, `cmd_out` is high and `irq` is low.
- R2: A command-word write with bit 12 set while idle sends, one bit per tick with `cmd_oe` high for exactly 48 ticks, the frame 0, 1, index (word bits 5:0), the 32-bit argument, CRC7 (polynomial x^7+x^3+1 over the first 40 bits) and a 1.
- R3: Response type 00 (word bits 9:8) ends after the last frame bit with status bit 7 (sent) set and the engine idle, without listening for a reply.
- R4: Response type 01 receives a 48-bit reply starting with a 0 start bit. Its bits 39:8 go to `resp0`. Status bit 6 (response end) is set when the received CRC7 in bits 7:1 matches the CRC computed over bits 47:8; otherwise only status bit 0 (CRC fail) is set.
- R5: Response type 10 receives a 48-bit reply into `resp0` and sets status bit 6 whatever its CRC field holds, never bit 0.
- R6: Response type 11 receives a 136-bit reply. The 128 bits after its first 8 bits fill `resp0` (most significant word) to `resp3`, and status bit 6 is set.
- R7: After the frame is sent, a start bit on any of the first 64 ticks is accepted. If none comes, status bit 2 (timeout) is set on the 64th tick and the engine goes idle.
- R8: Status bit 13 is high from the cycle after a start until the engine returns to idle.
- R9: Status flags stay set until a clear write has a 1 at the flag's bit position; 0 bits in a clear write leave flags unchanged.
- R10: `irq` is high when any of status bits 0, 2, 6, 7 is set with the mask bit at the same position set.
- R11: A command-word write with bit 12 clear while active returns the engine to idle on the next cycle, releases the line and sets no flag.
- R12: While `card_tick` is low, the engine holds its state and line output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_tick | input | 1 | One-cycle enable per card clock bit period |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: index 5:0, response type 9:8, go 12 |
| clr_we | input | 1 | Flag clear write strobe |
| clr_wdata | input | 32 | Ones clear the flags at the same positions |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 32 | Interrupt enables at the flag positions |
| status | output | 32 | Flags 0, 2, 6, 7 and active bit 13 |
| resp0 | output | 32 | Response word 0 (short reply content or long reply bits 127:96) |
| resp1 | output | 32 | Long reply bits 95:64 |
| resp2 | output | 32 | Long reply bits 63:32 |
| resp3 | output | 32 | Long reply bits 31:0 |
| irq | output | 1 | Masked flag interrupt |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line input value |

## Verification
The command exchange is tried with every response type and with replies that differ only in their CRC field. This separates a CRC check that is applied, skipped or applied to the wrong response type. Replies are started at the earliest tick and at the 64th tick after the frame, against a silent line, which pins the timeout boundary to one tick. Aborts mid-frame and stalls with `card_tick` low show that the line is released or held exactly when expected.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int RESP_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        card_tick,
  input  logic        arg_we,
  input  logic [31:0] arg_wdata,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        clr_we,
  input  logic [31:0] clr_wdata,
  input  logic        mask_we,
  input  logic [31:0] mask_wdata,
  output logic [31:0] status,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3,
  output logic        irq,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in
);
  localparam int TW = $clog2(RESP_TIMEOUT + 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(RESP_TIMEOUT - 1);

  typedef enum logic [1:0] {IDLE, SEND, WAIT, RECV} st_t;

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  st_t           st;
  logic [31:0]   arg_q;
  logic [1:0]    rtype;
  logic [47:0]   tx_sr;
  logic [135:0]  rx_sr;
  logic [7:0]    cnt;
  logic [TW-1:0] tmr;
  logic [3:0]    flags;   // {sent, rend, timeout, crc}
  logic [3:0]    mask_q;

  wire         active   = (st != IDLE);
  wire         start_w  = cmd_we && cmd_wdata[12] && !active;
  wire         abort_w  = cmd_we && !cmd_wdata[12] && active;
  wire [39:0]  tx_head  = {2'b01, cmd_wdata[5:0], arg_q};
  wire [7:0]   rx_len   = (rtype == 2'b11) ? 8'd136 : 8'd48;
  wire [135:0] rx_nx    = {rx_sr[134:0], cmd_in};
  wire         crc_ok   = (crc7(rx_nx[47:8]) == rx_nx[7:1]);
  wire         tx_last  = (st == SEND) && card_tick && (cnt == 8'd47);
  wire         rx_last  = (st == RECV) && card_tick && (cnt == rx_len - 8'd1);

  wire set_sent = tx_last && (rtype == 2'b00);
  wire set_to   = (st == WAIT) && card_tick && cmd_in && (tmr == TMR_LAST);
  wire set_rend = rx_last && ((rtype != 2'b01) || crc_ok);
  wire set_crc  = rx_last && (rtype == 2'b01) && !crc_ok;

  wire [3:0] set_vec = {set_sent, set_rend, set_to, set_crc};
  wire [3:0] clr_vec = clr_we ? {clr_wdata[7], clr_wdata[6], clr_wdata[2], clr_wdata[0]} : 4'b0;

  logic unused_bits;
  assign unused_bits = ^{cmd_wdata[31:13], cmd_wdata[11:10], cmd_wdata[7:6],
                         clr_wdata[31:8], clr_wdata[5:3], clr_wdata[1],
                         mask_wdata[31:8], mask_wdata[5:3], mask_wdata[1]};

  assign cmd_oe  = (st == SEND);
  assign cmd_out = (st == SEND) ? tx_sr[47] : 1'b1;
  assign status  = {18'b0, active, 5'b0, flags[3], flags[2], 3'b0, flags[1], 1'b0, flags[0]};
  assign irq     = |(flags & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q  <= '0;
      mask_q <= '0;
      flags  <= '0;
    end else begin
      if (arg_we)  arg_q  <= arg_wdata;
      if (mask_we) mask_q <= {mask_wdata[7], mask_wdata[6], mask_wdata[2], mask_wdata[0]};
      flags <= (flags & ~clr_vec) | set_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      rtype <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      cnt   <= '0;
      tmr   <= '0;
      resp0 <= '0;
      resp1 <= '0;
      resp2 <= '0;
      resp3 <= '0;
    end else if (abort_w) begin
      st <= IDLE;
    end else begin
      case (st)
        IDLE: if (start_w) begin
          tx_sr <= {tx_head, crc7(tx_head), 1'b1};
          rtype <= cmd_wdata[9:8];
          cnt   <= '0;
          st    <= SEND;
        end
        SEND: if (card_tick) begin
          tx_sr <= {tx_sr[46:0], 1'b1};
          cnt   <= cnt + 8'd1;
          if (tx_last) begin
            st  <= (rtype == 2'b00) ? IDLE : WAIT;
            tmr <= '0;
          end
        end
        WAIT: if (card_tick) begin
          if (!cmd_in) begin
            st    <= RECV;
            cnt   <= 8'd1;
            rx_sr <= rx_nx;
          end else if (tmr == TMR_LAST) begin
            st <= IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        RECV: if (card_tick) begin
          rx_sr <= rx_nx;
          cnt   <= cnt + 8'd1;
          if (rx_last) begin
            st <= IDLE;
            if (rtype == 2'b11) begin
              resp0 <= rx_nx[127:96];
              resp1 <= rx_nx[95:64];
              resp2 <= rx_nx[63:32];
              resp3 <= rx_nx[31:0];
            end else begin
              resp0 <= rx_nx[39:8];
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!cmd_oe && !status[13]));

  // R9
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((flags & $past(flags)) == $past(flags)));

  // R3
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> (!$rose(flags[2]) && !$rose(flags[1])));

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !card_tick && !cmd_we) |=> ($stable(tx_sr) && $stable(cnt) && $stable(cmd_oe)));

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (cmd_oe && !cmd_out));
endmodule

// File: tb/sd_cmd_engine_test.sv
`timescale 1ns/1ps
module sd_cmd_engine_test;
  logic clk = 0, rst_n = 0, card_tick = 1;
  logic arg_we = 0, cmd_we = 0, clr_we = 0, mask_we = 0;
  logic [31:0] arg_wdata = 0, cmd_wdata = 0, clr_wdata = 0, mask_wdata = 0;
  logic [31:0] status, resp0, resp1, resp2, resp3;
  logic irq, cmd_out, cmd_oe, cmd_in = 1;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_cmd_engine uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'b0};
    for (int i = 46; i >= 7; i--) if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic wr_arg(input logic [31:0] v);
    arg_wdata = v; arg_we = 1; @(negedge clk); arg_we = 0;
  endtask
  task automatic wr_cmd(input logic [31:0] v);
    cmd_wdata = v; cmd_we = 1; @(negedge clk); cmd_we = 0;
  endtask
  task automatic wr_clr(input logic [31:0] v);
    clr_wdata = v; clr_we = 1; @(negedge clk); clr_we = 0;
  endtask
  task automatic wr_mask(input logic [31:0] v);
    mask_wdata = v; mask_we = 1; @(negedge clk); mask_we = 0;
  endtask

  task automatic send_and_check(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt);
    logic [47:0] got, exp;
    bit oe_ok;
    exp = {2'b01, idx, arg, bcrc({2'b01, idx, arg}), 1'b1};
    wr_arg(arg);
    wr_cmd({16'b0, 3'b0, 1'b1, 2'b0, rt, 2'b0, idx});
    oe_ok = 1;
    got = '0;
    for (int i = 0; i < 48; i++) begin
      if (!cmd_oe) oe_ok = 0;
      got = {got[46:0], cmd_out};
      @(negedge clk);
    end
    chk(got == exp, "R2 frame", got[31:0], exp[31:0]);
    chk(oe_ok && !cmd_oe, "R2 oe window", {31'b0, cmd_oe}, 32'd0);
  endtask

  task automatic drive_resp(input logic [135:0] bits, input int len, input int gap);
    cmd_in = 1;
    for (int g = 0; g < gap; g++) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = bits[i];
      @(negedge clk);
    end
    cmd_in = 1;
  endtask

  function automatic logic [47:0] short_resp(input logic [5:0] idx, input logic [31:0] p, input bit bad);
    logic [39:0] h;
    h = {2'b00, idx, p};
    return {h, bcrc(h) ^ {6'b0, bad}, 1'b1};
  endfunction

  task automatic t_reset;
    chk(status == 0, "R1 status", status, 0);
    chk(!cmd_oe && cmd_out && !irq, "R1 line", {29'b0, cmd_oe, cmd_out, irq}, 32'b010);
  endtask

  task automatic t_no_resp;
    send_and_check(6'd0, 32'h1234_5678, 2'b00);
    chk(status == 32'h80, "R3 sent flag idle", status, 32'h80);
    wr_clr('1);
  endtask

  task automatic t_short(input logic [1:0] rt, input bit bad, input logic [31:0] p, input int gap);
    send_and_check(6'd17, 32'hA5A5_0F0F, rt);
    chk(status[13], "R8 active in wait", status, 32'h2000);
    drive_resp({88'b0, short_resp(6'd17, p, bad)}, 48, gap);
    if (rt == 2'b01 && bad) begin
      chk(status == 32'h01, "R4 crc fail flag", status, 32'h01);
    end else begin
      chk(status == 32'h40, rt == 2'b01 ? "R4 response end" : "R5 no crc check", status, 32'h40);
      chk(resp0 == p, rt == 2'b01 ? "R4 resp0" : "R5 resp0", resp0, p);
    end
    wr_clr('1);
  endtask

  task automatic t_long;
    logic [127:0] d;
    d = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA99};
    send_and_check(6'd2, 32'h0, 2'b11);
    drive_resp({2'b00, 6'h3f, d}, 136, 3);
    chk(status == 32'h40, "R6 response end", status, 32'h40);
    chk(resp0 == d[127:96], "R6 resp0", resp0, d[127:96]);
    chk(resp1 == d[95:64], "R6 resp1", resp1, d[95:64]);
    chk(resp2 == d[63:32], "R6 resp2", resp2, d[63:32]);
    chk(resp3 == d[31:0], "R6 resp3", resp3, d[31:0]);
    wr_clr('1);
  endtask

  task automatic t_timeout;
    send_and_check(6'd9, 32'h5, 2'b01);
    for (int i = 0; i < 63; i++) @(negedge clk);
    chk(status == 32'h2000, "R7 before timeout", status, 32'h2000);
    @(negedge clk);
    chk(status == 32'h04, "R7 timeout flag", status, 32'h04);
  endtask

  task automatic t_clear_irq;
    // timeout flag (bit 2) set from previous task
    wr_mask(32'h80);
    chk(!irq, "R10 unmasked flag", {31'b0, irq}, 0);
    wr_mask(32'h04);
    chk(irq, "R10 masked flag", {31'b0, irq}, 1);
    wr_clr(32'hFFFF_FFFB);
    chk(status == 32'h04, "R9 clear zero keeps", status, 32'h04);
    wr_clr(32'h04);
    chk(status == 0 && !irq, "R9 clear one", status, 0);
    wr_mask(32'h0);
  endtask

  task automatic t_abort;
    wr_arg(32'hFFFF_FFFF);
    wr_cmd(32'h1000 | 32'h100 | 32'd5);
    repeat (10) @(negedge clk);
    wr_cmd(32'h0);
    chk(!cmd_oe && cmd_out && status == 0, "R11 abort", status, 0);
  endtask

  task automatic t_stall;
    wr_cmd(32'h1000 | 32'd3);
    card_tick = 0;
    repeat (4) @(negedge clk);
    chk(cmd_oe && !cmd_out, "R12 hold start bit", {30'b0, cmd_oe, cmd_out}, 32'b10);
    card_tick = 1;
    @(negedge clk);
    chk(cmd_oe && cmd_out, "R12 resume", {30'b0, cmd_oe, cmd_out}, 32'b11);
    wr_cmd(32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_no_resp;
    t_short(2'b01, 0, 32'hCAFE_F00D, 5);
    t_short(2'b01, 1, 32'h1111_2222, 0);
    t_short(2'b10, 1, 32'h3333_4444, 2);
    t_short(2'b01, 0, 32'h7777_8888, 63);
    t_long;
    t_timeout;
    t_clear_irq;
    t_abort;
    t_stall;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule